// File: doc/BRIEF.md
# Lookup Table Indirect Access Port

This block gives a 32-bit register bus access to a table of wide lookup entries that is held in internal storage. An entry is 68 bits wide by default and does not fit in one bus word, so software moves entries through three staging data words. Software first writes an entry index, together with a direction flag, into a command register. When the flag is clear, the block copies the indexed entry into the staging words, and software then reads them. When the flag is set, the block writes whatever is in the staging words into the indexed entry.

Each command takes effect at the clock edge that accepts the bus write. The staging words hold the fetched data on the very next bus cycle. The word order is reversed relative to the entry bits: the staging word at the highest offset holds the least significant entry bits. Only the bits that exist in an entry are kept in the staging words. A read-only revision register lets software identify the block.

Top module: `tbl_access_port`

## Requirements
- R1: A read at byte offset 0x00 returns the revision word: bits 15:8 hold the major revision parameter, bits 7:0 hold the minor revision parameter, and bits 31:16 are zero. Writes to this offset have no effect.
- R2: The staging words at offsets 0x34 (word 0), 0x38 (word 1) and 0x3C (word 2) can be written and read back. Word 0 keeps only the entry bits above bit 63 (4 bits by default), and its other bits read as zero.
- R3: After reset, all three staging words and the command register read as zero.
- R4: A write to offset 0x20 with bit 31 set stores the staging words into the entry whose index is in bits 15:0. Word 2 goes to entry bits 31:0, word 1 to bits 63:32, and word 0 to bits 67:64.
- R5: A write to offset 0x20 with bit 31 clear loads the indexed entry into the three staging words, in the same word order as R4. The loaded values are readable on the next bus cycle.
- R6: A store command leaves the staging words unchanged. A load command replaces all three staging words.
- R7: A store command whose index is at or beyond the table depth (1024 by default) changes no entry.
- R8: A load command whose index is at or beyond the table depth sets all three staging words to zero.
- R9: A read at offset 0x20 returns the index field of the last command written, in bits 15:0. Bits 31:16 read as zero, so the direction flag is not returned.
- R10: A read at any other offset returns zero. A write to any other offset changes no staging word, no command register and no entry.
- R11: Entries that receive no store command keep their contents while other entries are stored and loaded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | 1 = write access, 0 = read access |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register; zero when there is no read access |

## Verification
The hardest condition to reach from the ports is proving that an out-of-range store left the table untouched. The table itself cannot be observed directly, so the stimulus first stores known patterns at the last valid index and at index 0. It then issues stores at the first invalid index and at the largest encodable index, with different staging contents. Finally it loads each of the valid entries back and compares them with the original patterns. The word order is made visible in a similar way: all ones are stored through every staging word, and only the existing upper bits return in word 0.

// File: rtl/tbl_access_pkg.sv
package tbl_access_pkg;

   localparam int WORD_W      = 32;
   localparam int ENTRY_WORDS = 3;
   localparam int IDX_FIELD_W = 16;
   localparam int STORE_BIT   = 31;

   localparam logic [7:0] OFF_ID  = 8'h00;
   localparam logic [7:0] OFF_CTL = 8'h20;
   localparam logic [7:0] OFF_W0  = 8'h34;
   localparam logic [7:0] OFF_W1  = 8'h38;
   localparam logic [7:0] OFF_W2  = 8'h3C;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_ID,
      SEL_CTL,
      SEL_W0,
      SEL_W1,
      SEL_W2
   } reg_sel_e;

   typedef logic [ENTRY_WORDS-1:0][WORD_W-1:0] word_set_t;

   // lowest entry bit held by staging word w (word order is reversed)
   function automatic int word_lsb(input int w);
      return WORD_W * (ENTRY_WORDS - 1 - w);
   endfunction

   // number of real entry bits held by staging word w
   function automatic int word_bits(input int w, input int entry_bits);
      int r;
      r = entry_bits - word_lsb(w);
      if (r > WORD_W) r = WORD_W;
      if (r < 0) r = 0;
      return r;
   endfunction

endpackage

// File: rtl/tbl_ctrl.sv
module tbl_ctrl
   import tbl_access_pkg::*;
#(
   parameter int DEPTH  = 1024,
   parameter int ADDR_W = 8,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   bus_sel,
   input  logic                   bus_wr,
   input  logic [ADDR_W-1:0]      bus_addr,
   input  logic [WORD_W-1:0]      bus_wdata,
   output reg_sel_e               sel_kind,
   output logic [ENTRY_WORDS-1:0] word_we,
   output logic                   cmd_load,
   output logic                   cmd_store,
   output logic                   cmd_in_range,
   output logic [IDX_W-1:0]       cmd_idx,
   output logic [IDX_FIELD_W-1:0] ctl_q
);

   localparam logic [IDX_FIELD_W:0] DEPTH_V = (IDX_FIELD_W + 1)'(DEPTH);

   logic                   wr_cycle;
   logic                   ctl_wr;
   logic [IDX_FIELD_W-1:0] idx_field;

   always_comb begin
      sel_kind = SEL_NONE;
      if (bus_addr == ADDR_W'(OFF_ID))  sel_kind = SEL_ID;
      if (bus_addr == ADDR_W'(OFF_CTL)) sel_kind = SEL_CTL;
      if (bus_addr == ADDR_W'(OFF_W0))  sel_kind = SEL_W0;
      if (bus_addr == ADDR_W'(OFF_W1))  sel_kind = SEL_W1;
      if (bus_addr == ADDR_W'(OFF_W2))  sel_kind = SEL_W2;
   end

   assign wr_cycle     = bus_sel & bus_wr;
   assign ctl_wr       = wr_cycle && (sel_kind == SEL_CTL);
   assign idx_field    = bus_wdata[IDX_FIELD_W-1:0];
   assign cmd_in_range = ({1'b0, idx_field} < DEPTH_V);
   assign cmd_idx      = idx_field[IDX_W-1:0];
   assign cmd_store    = ctl_wr &  bus_wdata[STORE_BIT];
   assign cmd_load     = ctl_wr & ~bus_wdata[STORE_BIT];

   assign word_we[0] = wr_cycle && (sel_kind == SEL_W0);
   assign word_we[1] = wr_cycle && (sel_kind == SEL_W1);
   assign word_we[2] = wr_cycle && (sel_kind == SEL_W2);

   always_ff @(posedge clk) begin
      if (!rst_n)      ctl_q <= '0;
      else if (ctl_wr) ctl_q <= idx_field;
   end

endmodule

// File: rtl/tbl_store.sv
module tbl_store #(
   parameter int DEPTH      = 1024,
   parameter int ENTRY_BITS = 68,
   localparam int IDX_W     = $clog2(DEPTH)
) (
   input  logic                  clk,
   input  logic                  wr_en,
   input  logic [IDX_W-1:0]      wr_idx,
   input  logic [ENTRY_BITS-1:0] wr_data,
   input  logic [IDX_W-1:0]      rd_idx,
   output logic [ENTRY_BITS-1:0] rd_data
);

   logic [ENTRY_BITS-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_idx] <= wr_data;
   end

   assign rd_data = mem[rd_idx];

endmodule

// File: rtl/tbl_words.sv
module tbl_words
   import tbl_access_pkg::*;
#(
   parameter int ENTRY_BITS = 68
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [ENTRY_WORDS-1:0] word_we,
   input  logic [WORD_W-1:0]      wdata,
   input  logic                   load_en,
   input  logic                   load_zero,
   input  logic [ENTRY_BITS-1:0]  entry_in,
   output word_set_t              words,
   output logic [ENTRY_BITS-1:0]  entry_out
);

   for (genvar w = 0; w < ENTRY_WORDS; w++) begin : g_word
      localparam int LSB  = word_lsb(w);
      localparam int BITS = word_bits(w, ENTRY_BITS);

      logic [BITS-1:0] q;

      always_ff @(posedge clk) begin
         if (!rst_n)          q <= '0;
         else if (load_en)    q <= load_zero ? '0 : entry_in[LSB +: BITS];
         else if (word_we[w]) q <= wdata[BITS-1:0];
      end

      if (BITS == WORD_W) begin : g_full
         assign words[w] = q;
      end else begin : g_part
         assign words[w] = {{(WORD_W - BITS){1'b0}}, q};
      end

      assign entry_out[LSB +: BITS] = q;
   end

endmodule

// File: rtl/tbl_access_port.sv
module tbl_access_port
   import tbl_access_pkg::*;
#(
   parameter int           DEPTH      = 1024,
   parameter int           ENTRY_BITS = 68,
   parameter int           ADDR_W     = 8,
   parameter logic [7:0]   REV_MAJOR  = 8'h01,
   parameter logic [7:0]   REV_MINOR  = 8'h03
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata
);

   localparam int IDX_W = $clog2(DEPTH);

   if (DEPTH < 2 || DEPTH > (1 << IDX_FIELD_W)) begin : g_bad_depth
      $error("tbl_access_port: DEPTH out of range");
   end
   if (ENTRY_BITS <= WORD_W * (ENTRY_WORDS - 1) || ENTRY_BITS > WORD_W * ENTRY_WORDS) begin : g_bad_width
      $error("tbl_access_port: ENTRY_BITS must span exactly three words");
   end
   if (ADDR_W < 8) begin : g_bad_addr
      $error("tbl_access_port: ADDR_W too small for the register map");
   end

   reg_sel_e               sel_kind;
   logic [ENTRY_WORDS-1:0] word_we;
   logic                   cmd_load;
   logic                   cmd_store;
   logic                   cmd_in_range;
   logic [IDX_W-1:0]       cmd_idx;
   logic [IDX_FIELD_W-1:0] ctl_q;
   logic [ENTRY_BITS-1:0]  mem_rd;
   logic [ENTRY_BITS-1:0]  staged;
   word_set_t              data_words;

   tbl_ctrl #(
      .DEPTH  (DEPTH),
      .ADDR_W (ADDR_W)
   ) u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .bus_sel      (bus_sel),
      .bus_wr       (bus_wr),
      .bus_addr     (bus_addr),
      .bus_wdata    (bus_wdata),
      .sel_kind     (sel_kind),
      .word_we      (word_we),
      .cmd_load     (cmd_load),
      .cmd_store    (cmd_store),
      .cmd_in_range (cmd_in_range),
      .cmd_idx      (cmd_idx),
      .ctl_q        (ctl_q)
   );

   tbl_store #(
      .DEPTH      (DEPTH),
      .ENTRY_BITS (ENTRY_BITS)
   ) u_store (
      .clk     (clk),
      .wr_en   (cmd_store & cmd_in_range),
      .wr_idx  (cmd_idx),
      .wr_data (staged),
      .rd_idx  (cmd_idx),
      .rd_data (mem_rd)
   );

   tbl_words #(
      .ENTRY_BITS (ENTRY_BITS)
   ) u_words (
      .clk       (clk),
      .rst_n     (rst_n),
      .word_we   (word_we),
      .wdata     (bus_wdata),
      .load_en   (cmd_load),
      .load_zero (~cmd_in_range),
      .entry_in  (mem_rd),
      .words     (data_words),
      .entry_out (staged)
   );

   always_comb begin
      bus_rdata = '0;
      if (bus_sel && !bus_wr) begin
         case (sel_kind)
            SEL_ID:  bus_rdata = {16'h0000, REV_MAJOR, REV_MINOR};
            SEL_CTL: bus_rdata = {{(32 - IDX_FIELD_W){1'b0}}, ctl_q};
            SEL_W0:  bus_rdata = data_words[0];
            SEL_W1:  bus_rdata = data_words[1];
            SEL_W2:  bus_rdata = data_words[2];
            default: bus_rdata = '0;
         endcase
      end
   end

endmodule

// File: rtl/tbl_access_port_chk.sv
module tbl_access_port_chk
   import tbl_access_pkg::*;
#(
   parameter int         DEPTH      = 1024,
   parameter int         ENTRY_BITS = 68,
   parameter int         ADDR_W     = 8,
   parameter logic [7:0] REV_MAJOR  = 8'h01,
   parameter logic [7:0] REV_MINOR  = 8'h03
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [31:0]       bus_wdata,
   input logic [31:0]       bus_rdata,
   input word_set_t         words
);

   localparam int W0_BITS = word_bits(0, ENTRY_BITS);
   localparam logic [16:0] DEPTH_V = 17'(DEPTH);

   logic ctl_write;
   logic is_read;
   assign ctl_write = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFF_CTL));
   assign is_read   = bus_sel && !bus_wr;

   // R1
   id_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (is_read && bus_addr == ADDR_W'(OFF_ID)) |-> bus_rdata == {16'h0000, REV_MAJOR, REV_MINOR});

   // R2
   word0_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (words[0] >> W0_BITS) == '0);

   // R2
   word1_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_wr && bus_addr == ADDR_W'(OFF_W1)) |=> words[1] == $past(bus_wdata));

   // R6
   store_keeps_words_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_write && bus_wdata[STORE_BIT]) |=> $stable(words));

   // R8
   oor_load_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_write && !bus_wdata[STORE_BIT] && {1'b0, bus_wdata[15:0]} >= DEPTH_V) |=> words == '0);

   // R9
   ctl_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_write |=> (is_read && bus_addr == ADDR_W'(OFF_CTL)) -> bus_rdata == {16'h0000, $past(bus_wdata[15:0])});

endmodule

bind tbl_access_port tbl_access_port_chk #(
   .DEPTH      (DEPTH),
   .ENTRY_BITS (ENTRY_BITS),
   .ADDR_W     (ADDR_W),
   .REV_MAJOR  (REV_MAJOR),
   .REV_MINOR  (REV_MINOR)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_sel   (bus_sel),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .words     (data_words)
);

// File: tb/tbl_access_port_bench.sv
`timescale 1ns/1ps
module tbl_access_port_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;

   int checks = 0;
   int errors = 0;
   logic [31:0] rd;

   always #2.5 clk = ~clk;

   tbl_access_port u_tbl_access_port (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_sel   (bus_sel),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
   endtask

   task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
   endtask

   function automatic logic [31:0] pat(input int k, input int w);
      logic [31:0] v;
      v = 32'h9E37_79B9 * (k + 1) + 32'h0101_0101 * (w + 3);
      if (w == 0) v = v & 32'h0000_000F;
      return v;
   endfunction

   task automatic put_words(input logic [31:0] a0, input logic [31:0] a1, input logic [31:0] a2);
      bus_write(8'h34, a0);
      bus_write(8'h38, a1);
      bus_write(8'h3C, a2);
   endtask

   task automatic expect_words(input string req, input logic [31:0] e0, input logic [31:0] e1, input logic [31:0] e2);
      bus_read(8'h34, rd); check(req, rd, e0);
      bus_read(8'h38, rd); check(req, rd, e1);
      bus_read(8'h3C, rd); check(req, rd, e2);
   endtask

   task automatic t_reset;
      // R3
      expect_words("R3 reset words", 32'h0, 32'h0, 32'h0);
      bus_read(8'h20, rd); check("R3 reset ctl", rd, 32'h0);
   endtask

   task automatic t_id;
      bus_read(8'h00, rd); check("R1 id", rd, 32'h0000_0103);
      bus_write(8'h00, 32'hFFFF_FFFF);
      bus_read(8'h00, rd); check("R1 id after write", rd, 32'h0000_0103);
   endtask

   task automatic t_word_rw;
      put_words(32'hFFFF_FFFF, 32'hDEAD_BEEF, 32'h1234_5678);
      // R2: word 0 keeps only 4 bits
      expect_words("R2 word rw", 32'h0000_000F, 32'hDEAD_BEEF, 32'h1234_5678);
   endtask

   task automatic t_store_load;
      // R4 R5: store several entries, scramble the words, load each back
      for (int k = 0; k < 6; k++) begin
         put_words(pat(k, 0), pat(k, 1), pat(k, 2));
         bus_write(8'h20, 32'h8000_0000 | (k * 97));
      end
      for (int k = 5; k >= 0; k--) begin
         put_words(32'h5, 32'hAAAA_AAAA, 32'h5555_5555);
         bus_write(8'h20, k * 97);
         expect_words("R5 load", pat(k, 0), pat(k, 1), pat(k, 2));
      end
   endtask

   task automatic t_store_keeps;
      put_words(32'h3, 32'h0F0F_0F0F, 32'hF0F0_F0F0);
      bus_write(8'h20, 32'h8000_0010);
      // R6: store leaves staging words unchanged
      expect_words("R6 store keeps", 32'h3, 32'h0F0F_0F0F, 32'hF0F0_F0F0);
      put_words(32'h0, 32'h0, 32'h0);
      bus_write(8'h20, 32'h0000_0010);
      expect_words("R4 roundtrip", 32'h3, 32'h0F0F_0F0F, 32'hF0F0_F0F0);
   endtask

   task automatic t_oor_store;
      put_words(32'hA, 32'h1111_2222, 32'h3333_4444);
      bus_write(8'h20, 32'h8000_03FF);
      put_words(32'h6, 32'h7777_8888, 32'h9999_0000);
      bus_write(8'h20, 32'h8000_0000);
      put_words(32'h1, 32'hBAD0_BAD0, 32'hBAD1_BAD1);
      bus_write(8'h20, 32'h8000_0400);
      bus_write(8'h20, 32'h8000_FFFF);
      bus_write(8'h20, 32'h0000_03FF);
      expect_words("R7 last entry intact", 32'hA, 32'h1111_2222, 32'h3333_4444);
      bus_write(8'h20, 32'h0000_0000);
      expect_words("R7 entry0 intact", 32'h6, 32'h7777_8888, 32'h9999_0000);
   endtask

   task automatic t_oor_load;
      put_words(32'hF, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
      bus_write(8'h20, 32'h0000_0400);
      expect_words("R8 oor load", 32'h0, 32'h0, 32'h0);
      put_words(32'hF, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
      bus_write(8'h20, 32'h0000_FFFF);
      expect_words("R8 oor load max", 32'h0, 32'h0, 32'h0);
   endtask

   task automatic t_ctl_readback;
      bus_write(8'h20, 32'h8000_0123);
      bus_read(8'h20, rd); check("R9 ctl store readback", rd, 32'h0000_0123);
      bus_write(8'h20, 32'h0000_0456);
      bus_read(8'h20, rd); check("R9 ctl load readback", rd, 32'h0000_0456);
   endtask

   task automatic t_unmapped;
      put_words(32'h2, 32'hCAFE_0001, 32'hCAFE_0002);
      bus_write(8'h44, 32'hFFFF_FFFF);
      bus_write(8'h35, 32'hFFFF_FFFF);
      bus_write(8'h24, 32'h8000_0000);
      bus_read(8'h44, rd); check("R10 unmapped read", rd, 32'h0);
      bus_read(8'h08, rd); check("R10 unmapped read", rd, 32'h0);
      expect_words("R10 words intact", 32'h2, 32'hCAFE_0001, 32'hCAFE_0002);
      bus_read(8'h20, rd); check("R10 ctl intact", rd, 32'h0000_0456);
      // R11: entry 0 must still hold the value stored earlier
      bus_write(8'h20, 32'h0000_0000);
      expect_words("R11 entry0 retained", 32'h6, 32'h7777_8888, 32'h9999_0000);
   endtask

   initial begin
      #(200000 * 5);
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset;
      t_id;
      t_word_rw;
      t_store_load;
      t_store_keeps;
      t_oor_store;
      t_oor_load;
      t_ctl_readback;
      t_unmapped;
      @(negedge clk);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule